// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Data-Register Selector

This block holds the instruction side of a boundary-scan test port. An external TAP controller tells it which state it is in, one indication per state. From those indications and the test clock it runs a 3-bit instruction shift stage and keeps a latched parallel instruction beside it. It decodes that instruction into a data-register choice, keeps a single-bit bypass register and a 32-bit identification register, and chooses which register drives the serial test output.

The boundary-scan cell chain is outside the block. The block gives that chain capture, shift and update strobes, which are active only while the chain is selected. It also gives two pin-control lines. The first makes the boundary outputs follow the scan cells, for EXTEST and CLAMP. The second floats the boundary outputs, for HIGH-Z. The serial output changes on the falling test-clock edge. A separate enable marks the cycles in which the serial output carries data.

The opcodes are fixed. 000 is EXTEST, 001 is IDCODE, 010 is SAMPLE/PRELOAD, 011 is CLAMP, 100 is HIGH-Z and 111 is BYPASS. Codes 101 and 110 have no instruction and act like BYPASS.

Top module: `tap_instr_select`

## Requirements
- R1: While `trst_n` is low, `instr` reads 001 (IDCODE), asynchronously. A falling clock edge in Test-Logic-Reset also sets `instr` to 001.
- R2: A rising edge in Capture-IR loads 001 into the instruction shift stage. The first two bits shifted out on `tdo` are therefore 1 and then 0.
- R3: Each rising edge in Shift-IR moves the shift stage one place toward `tdo`, and `tdi` enters at the far end. The bits of an opcode therefore leave `tdo` bit 0 first.
- R4: In Update-IR the shift-stage value reaches `instr` on the falling edge of that cycle and not before it.
- R5: The selected data register follows the opcode. 000 and 010 select the boundary chain, 001 selects the identification register, and 011, 100, 101, 110 and 111 select the bypass register. `bsr_sel` is 1 only when the boundary chain is selected.
- R6: With the bypass register selected, Capture-DR loads 0 into it. In Shift-DR, `tdo` then gives `tdi` one cycle later.
- R7: With the identification register selected, Capture-DR loads 32'h0000D143. Shift-DR sends this value out bit 0 first, and bit 0 is 1. The bits taken in from `tdi` follow it 32 shifts later.
- R8: `tdo` and `tdo_oe` are updated on the falling clock edge. `tdo_oe` is 1 only in the cycles of Shift-IR and Shift-DR, and 0 in every other state.
- R9: `bsr_drive` is 1 exactly when the opcode is 000 (EXTEST) or 011 (CLAMP). `pins_hiz` is 1 exactly when the opcode is 100 (HIGH-Z).
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` follow Capture-DR, Shift-DR and Update-DR, but only while `bsr_sel` is 1. In Shift-DR with `bsr_sel` set, `tdo` gives `bsr_so`.
- R11: Shifting and capturing in the instruction stage leave `instr` unchanged until Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| st_tlr | input | 1 | Controller is in Test-Logic-Reset |
| st_cap_ir | input | 1 | Controller is in Capture-IR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_upd_ir | input | 1 | Controller is in Update-IR |
| st_cap_dr | input | 1 | Controller is in Capture-DR |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| st_upd_dr | input | 1 | Controller is in Update-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| instr | output | 3 | Latched parallel instruction |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Capture strobe to the boundary chain |
| bsr_shift | output | 1 | Shift strobe to the boundary chain |
| bsr_update | output | 1 | Update strobe to the boundary chain |
| bsr_drive | output | 1 | Boundary outputs follow the scan cells |
| pins_hiz | output | 1 | Boundary outputs float |

## Verification
Some properties are checked on every clock edge:
- the Test-Logic-Reset load of `instr`;
- the Capture-IR pattern;
- the one-place shift move;
- `instr` holding still between updates;
- the one-cycle bypass delay;
- the identification value loaded at capture;
- the IDCODE routing;
- `tdo_oe` following the shift states.

Other behaviour shows only through the bench's scenarios. These cover the full opcode table with its pin-control lines and strobes, and the serial read-back of the capture pattern and of a full identification word. They also check that `tdi` returns 32 shifts later, that an asynchronous reset lands mid-run, and the half-cycle timing of `instr` and `tdo` around the falling edge.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  // Pattern captured into the shift stage in Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    DR_BSR = 2'd0,
    DR_BYP = 2'd1,
    DR_ID  = 2'd2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    drive;
    logic    hiz;
  } decode_t;

endpackage

// File: rtl/tapsel_rstsync.sv
module tapsel_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tapsel_ir.sv
module tapsel_ir
  import tapsel_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            st_tlr,
  input  logic            st_cap_ir,
  input  logic            st_shift_ir,
  input  logic            st_upd_ir,
  input  logic            tdi,
  output logic            ir_so,
  output logic [IR_W-1:0] instr
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] par_q, par_d;
  logic            par_en;

  // Shift stage: rising edge
  always_comb begin
    sr_en = st_cap_ir | st_shift_ir;
    sr_d  = sr_q;
    if (st_cap_ir)        sr_d = IR_CAPTURE;
    else if (st_shift_ir) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= IR_CAPTURE;
    else if (sr_en) sr_q <= sr_d;
  end

  // Parallel instruction: falling edge
  always_comb begin
    par_en = st_tlr | st_upd_ir;
    par_d  = par_q;
    if (st_tlr)         par_d = OP_IDCODE;
    else if (st_upd_ir) par_d = sr_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      par_q <= OP_IDCODE;
    else if (par_en) par_q <= par_d;
  end

  assign ir_so = sr_q[0];
  assign instr = par_q;

  // R1
  tlr_loads_id_chk: assert property (@(negedge tck) disable iff (!rst_n)
    st_tlr |=> (instr == OP_IDCODE));

  // R2
  capir_pattern_chk: assert property (@(posedge tck) disable iff (!rst_n)
    st_cap_ir |=> (sr_q == IR_CAPTURE));

  // R3
  shift_move_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st_shift_ir && !st_cap_ir) |=> (sr_q == {$past(tdi), $past(sr_q[IR_W-1:1])}));

  // R11
  par_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (!st_upd_ir && !st_tlr) |=> $stable(instr));

endmodule

// File: rtl/tapsel_decode.sv
module tapsel_decode
  import tapsel_pkg::*;
(
  input  logic [IR_W-1:0] instr,
  output decode_t         dec
);

  always_comb begin
    dec.dr    = DR_BYP;
    dec.drive = 1'b0;
    dec.hiz   = 1'b0;
    case (instr)
      OP_EXTEST: begin dec.dr = DR_BSR; dec.drive = 1'b1; end
      OP_SAMPLE: dec.dr = DR_BSR;
      OP_IDCODE: dec.dr = DR_ID;
      OP_CLAMP:  dec.drive = 1'b1;
      OP_HIGHZ:  dec.hiz = 1'b1;
      default:   dec.dr = DR_BYP;
    endcase
  end

endmodule

// File: rtl/tapsel_dregs.sv
module tapsel_dregs
  import tapsel_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000D143
) (
  input  logic    tck,
  input  logic    rst_n,
  input  logic    st_cap_dr,
  input  logic    st_shift_dr,
  input  dr_sel_e sel,
  input  logic    tdi,
  output logic    byp_so,
  output logic    id_so
);

  logic            byp_q, byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;
  logic            byp_act, id_act;

  always_comb begin
    byp_act = (sel == DR_BYP);
    id_act  = (sel == DR_ID);
  end

  // Bypass register
  always_comb begin
    byp_en = byp_act & (st_cap_dr | st_shift_dr);
    byp_d  = st_cap_dr ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // Identification register
  always_comb begin
    id_en = id_act & (st_cap_dr | st_shift_dr);
    id_d  = st_cap_dr ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_VALUE;
    else if (id_en) id_q <= id_d;
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];

  // R6
  byp_delay_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st_shift_dr && !st_cap_dr && byp_act) |=> (byp_so == $past(tdi)));

  // R7
  id_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st_cap_dr && id_act) |=> (id_q == ID_VALUE));

endmodule

// File: rtl/tap_instr_select.sv
module tap_instr_select
  import tapsel_pkg::*;
#(
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE    = 32'h0000D143,
  parameter int              SYNC_STAGES = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            st_tlr,
  input  logic            st_cap_ir,
  input  logic            st_shift_ir,
  input  logic            st_upd_ir,
  input  logic            st_cap_dr,
  input  logic            st_shift_dr,
  input  logic            st_upd_dr,
  input  logic            tdi,
  input  logic            bsr_so,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [IR_W-1:0] instr,
  output logic            bsr_sel,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            bsr_drive,
  output logic            pins_hiz
);

  logic    rst_n;
  logic    ir_so, byp_so, id_so;
  decode_t dec;
  logic    tdo_q, tdo_d, oe_q, oe_d;
  logic    dr_bit;

  tapsel_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  tapsel_ir u_ir (
    .tck         (tck),
    .rst_n       (rst_n),
    .st_tlr      (st_tlr),
    .st_cap_ir   (st_cap_ir),
    .st_shift_ir (st_shift_ir),
    .st_upd_ir   (st_upd_ir),
    .tdi         (tdi),
    .ir_so       (ir_so),
    .instr       (instr)
  );

  tapsel_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  tapsel_dregs #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck         (tck),
    .rst_n       (rst_n),
    .st_cap_dr   (st_cap_dr),
    .st_shift_dr (st_shift_dr),
    .sel         (dec.dr),
    .tdi         (tdi),
    .byp_so      (byp_so),
    .id_so       (id_so)
  );

  // Boundary chain controls
  always_comb begin
    bsr_sel     = (dec.dr == DR_BSR);
    bsr_capture = bsr_sel & st_cap_dr;
    bsr_shift   = bsr_sel & st_shift_dr;
    bsr_update  = bsr_sel & st_upd_dr;
    bsr_drive   = dec.drive;
    pins_hiz    = dec.hiz;
  end

  // Serial output multiplexer, falling edge
  always_comb begin
    case (dec.dr)
      DR_BSR:  dr_bit = bsr_so;
      DR_ID:   dr_bit = id_so;
      default: dr_bit = byp_so;
    endcase
    oe_d  = st_shift_ir | st_shift_dr;
    tdo_d = tdo_q;
    if (st_shift_ir)      tdo_d = ir_so;
    else if (st_shift_dr) tdo_d = dr_bit;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R5
  idcode_route_chk: assert property (@(negedge tck) disable iff (!rst_n)
    st_upd_ir |=> ((instr == OP_IDCODE) == (dec.dr == DR_ID)));

  // R8
  oe_shift_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (st_shift_ir || st_shift_dr) |=> tdo_oe);

  // R8
  oe_idle_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (!st_shift_ir && !st_shift_dr) |=> !tdo_oe);

endmodule

// File: tb/sim_tap_instr_select.sv
module sim_tap_instr_select;

  logic       tck = 1'b0;
  logic       trst_n;
  logic       st_tlr, st_cap_ir, st_shift_ir, st_upd_ir;
  logic       st_cap_dr, st_shift_dr, st_upd_dr;
  logic       tdi, bsr_so;
  logic       tdo, tdo_oe;
  logic [2:0] instr;
  logic       bsr_sel, bsr_capture, bsr_shift, bsr_update, bsr_drive, pins_hiz;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 tck = ~tck;

  tap_instr_select u0 (
    .tck(tck), .trst_n(trst_n), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_shift_dr(st_shift_dr), .st_upd_dr(st_upd_dr), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .instr(instr), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bsr_drive(bsr_drive), .pins_hiz(pins_hiz)
  );

  // State codes used by the bench
  localparam int S_IDLE = 0, S_TLR = 1, S_CIR = 2, S_SIR = 3, S_UIR = 4;
  localparam int S_CDR = 5, S_SDR = 6, S_UDR = 7;

  // {opcode[2:0], bsr_sel, bsr_drive, pins_hiz, tdo shift1, tdo shift2}
  localparam logic [7:0] VEC [8] = '{
    8'b000_1_1_0_00,  // EXTEST
    8'b001_0_0_0_11,  // IDCODE
    8'b010_1_0_0_00,  // SAMPLE/PRELOAD
    8'b011_0_1_0_01,  // CLAMP
    8'b100_0_0_1_01,  // HIGH-Z
    8'b101_0_0_0_01,  // undefined
    8'b110_0_0_0_01,  // undefined
    8'b111_0_0_0_01   // BYPASS
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_state(input int s, input logic d);
    st_tlr      = (s == S_TLR);
    st_cap_ir   = (s == S_CIR);
    st_shift_ir = (s == S_SIR);
    st_upd_ir   = (s == S_UIR);
    st_cap_dr   = (s == S_CDR);
    st_shift_dr = (s == S_SDR);
    st_upd_dr   = (s == S_UDR);
    tdi         = d;
  endtask

  // One controller cycle: state applied just after the rising edge, returns after the falling edge
  task automatic cyc(input int s, input logic d);
    @(posedge tck);
    #5;
    drive_state(s, d);
    #10;
  endtask

  task automatic load_ir(input logic [2:0] op);
    cyc(S_CIR, 1'b0);
    for (int i = 0; i < 3; i++) cyc(S_SIR, op[i]);
    cyc(S_IDLE, 1'b0);
    cyc(S_UIR, 1'b0);
    cyc(S_IDLE, 1'b0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] pat;
    logic        t1, t2;
    trst_n = 1'b0;
    bsr_so = 1'b0;
    drive_state(S_IDLE, 1'b0);
    #45;
    // R1 reset state
    check("R1 instr in reset", instr, 3'b001);
    check("R8 tdo_oe in reset", tdo_oe, 1'b0);
    trst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(S_IDLE, 1'b0);
    check("R1 instr after reset", instr, 3'b001);

    // R7 identification capture and shift
    cyc(S_CDR, 1'b0);
    pat = 32'hA5C3_3C5A;
    got = '0;
    for (int i = 0; i < 32; i++) begin
      cyc(S_SDR, pat[i]);
      got[i] = tdo;
    end
    check("R7 id word", got, 32'h0000D143);
    check("R8 tdo_oe in Shift-DR", tdo_oe, 1'b1);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      cyc(S_SDR, 1'b0);
      got[i] = tdo;
    end
    check("R7 tdi returns after 32", got, pat);
    cyc(S_IDLE, 1'b0);
    check("R8 tdo_oe idle", tdo_oe, 1'b0);

    // R2, R3, R11: capture pattern read back, then opcode bits come out after it
    cyc(S_CIR, 1'b0);
    got = '0;
    cyc(S_SIR, 1'b0); got[0] = tdo;
    cyc(S_SIR, 1'b1); got[1] = tdo;
    cyc(S_SIR, 1'b1); got[2] = tdo;
    check("R2 capture readback", got[2:0], 3'b001);
    check("R11 instr held during shift", instr, 3'b001);
    cyc(S_SIR, 1'b0); got[3] = tdo;
    cyc(S_SIR, 1'b0); got[4] = tdo;
    cyc(S_SIR, 1'b0); got[5] = tdo;
    check("R3 shifted bits lsb first", got[5:3], 3'b110);
    cyc(S_IDLE, 1'b0);
    check("R11 instr held before update", instr, 3'b001);
    cyc(S_UIR, 1'b0);
    check("R3 instr after zero fill", instr, 3'b000);

    // R4 falling-edge update timing
    cyc(S_CIR, 1'b0);
    for (int i = 0; i < 3; i++) cyc(S_SIR, 1'b1);
    cyc(S_IDLE, 1'b0);
    @(posedge tck);
    #5;
    drive_state(S_UIR, 1'b0);
    #2;
    check("R4 instr before falling edge", instr, 3'b000);
    #6;
    check("R4 instr after falling edge", instr, 3'b111);
    cyc(S_IDLE, 1'b0);

    // R6, R8 bypass delay and tdo falling-edge timing
    cyc(S_CDR, 1'b0);
    cyc(S_SDR, 1'b1);
    check("R6 bypass captured zero", tdo, 1'b0);
    @(posedge tck);
    #5;
    drive_state(S_SDR, 1'b0);
    #2;
    check("R8 tdo before falling edge", tdo, 1'b0);
    #6;
    check("R6 R8 tdo after falling edge", tdo, 1'b1);
    cyc(S_SDR, 1'b0);
    check("R6 bypass second bit", tdo, 1'b0);
    cyc(S_IDLE, 1'b0);

    // Table walk: R5 R9 for every opcode
    foreach (VEC[k]) begin
      load_ir(VEC[k][7:5]);
      check("R5 instr loaded", instr, VEC[k][7:5]);
      check("R5 bsr_sel", bsr_sel, VEC[k][4]);
      check("R9 bsr_drive", bsr_drive, VEC[k][3]);
      check("R9 pins_hiz", pins_hiz, VEC[k][2]);
      cyc(S_CDR, 1'b1);
      check("R10 capture strobe", bsr_capture, VEC[k][4]);
      cyc(S_SDR, 1'b1); t1 = tdo;
      check("R10 shift strobe", bsr_shift, VEC[k][4]);
      cyc(S_SDR, 1'b1); t2 = tdo;
      check("R5 dr path bit1", t1, VEC[k][1]);
      check("R5 dr path bit2", t2, VEC[k][0]);
      cyc(S_UDR, 1'b0);
      check("R10 update strobe", bsr_update, VEC[k][4]);
      cyc(S_IDLE, 1'b0);
    end

    // R10 boundary chain reaches tdo under EXTEST
    load_ir(3'b000);
    bsr_so = 1'b1;
    cyc(S_CDR, 1'b0);
    cyc(S_SDR, 1'b0);
    check("R10 tdo follows bsr_so", tdo, 1'b1);
    bsr_so = 1'b0;
    cyc(S_IDLE, 1'b0);

    // R1 Test-Logic-Reset forces IDCODE
    load_ir(3'b100);
    check("R1 pre-TLR instr", instr, 3'b100);
    cyc(S_TLR, 1'b0);
    check("R1 TLR instr", instr, 3'b001);
    cyc(S_IDLE, 1'b0);

    // R1 asynchronous reset mid-run
    load_ir(3'b011);
    #1;
    trst_n = 1'b0;
    #1;
    check("R1 async reset instr", instr, 3'b001);
    check("R9 drive off after reset", bsr_drive, 1'b0);
    trst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(S_IDLE, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule